// File: doc/BRIEF.md
# SMBus Slave Bus-Timeout Watchdog

This block sits beside an SMBus slave and watches the clock and data lines that the slave receives. It follows each transaction from its START to its STOP. It enforces two timing rules on the master. The first rule is a budget on the total time SCL spends low inside one transaction. Every low interval adds to the budget, and a long low that is broken up by short highs still counts in full. The second rule is a bound on how long SCL may stay high without a break while a transaction is open. When either rule is broken, the block sends a one-cycle reset pulse to the slave's protocol state machine. That reset makes the slave stop acknowledging, so a write that was cut off is never committed.

Both limits are set in microseconds and turned into clock-cycle counts at elaboration time from a clock-frequency parameter. A one-bit input picks the pair of limits to use. The slower-grade pair is the looser one, so that the bus timing stays the same when the chip's base clock is slower. While the chip is held in synchronous reset, the watchdog stays idle and does not track transactions.

Top module: `smbus_tmo_mon`

## Requirements
- R1: A transaction opens when SDA falls while SCL is high, and closes when SDA rises while SCL is high. SDA changes made while SCL is low neither open nor close a transaction.
- R2: While a transaction is open, every clock cycle with SCL low adds one to a running low total. The intervals add up across every SCL high phase in between. When the total reaches the selected low limit, `bus_rst_o` pulses on the third clock edge after the edge that completed the total. With a single uninterrupted low interval, this is the limit plus three edges after the SCL fall reaches the input pins.
- R3: With `grade_slow_i` = 0 the low limit is 30000 µs and the high limit is 60 µs. With `grade_slow_i` = 1 they are 37500 µs and 75 µs. Each is converted to floor(µs × CLK_HZ / 1e6) clock cycles.
- R4: The low total is cleared by every START, including a repeated START inside an open transaction, and by every STOP. Low time from an earlier transaction, or from before a repeated START, never counts toward a later timeout.
- R5: While a transaction is open, SCL held high for the selected high limit in cycles fires `bus_rst_o`. With SCL high from the START onward, the pulse comes high-limit + 4 edges after SDA falls at the pins. Each SCL low restarts this count. On an idle bus, SCL held high has no effect.
- R6: `bus_rst_o` is high for exactly one clock cycle. After it fires, both counts are zero and the transaction is closed, so neither SCL low nor SCL high causes another pulse until the next START.
- R7: `rst` is synchronous and active high. While it is asserted, `bus_rst_o` stays low and no transaction is tracked. A START seen only during reset does not open a transaction after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line as seen by the slave (asynchronous) |
| sda_i | input | 1 | SDA line as seen by the slave (asynchronous) |
| grade_slow_i | input | 1 | Limit pair select: 0 = faster grade (tighter), 1 = slower grade (looser) |
| bus_rst_o | output | 1 | One-cycle reset pulse to the slave protocol state machine |

## Verification
The low-time budget is driven with transactions made of repeated SCL low chunks split by short high phases. Some stay below the limit, some land exactly on it, and some cross it partway through a chunk. This tells true accumulation apart from a check on one continuous low, and it pins the firing cycle to the chunk and offset where the total is reached. The same patterns are run under both grade settings. This separates the two limit pairs, and it shows that each new transaction starts from zero because the earlier below-limit totals never make a later transaction fire early. Other patterns toggle SDA inside low phases, or issue a repeated START halfway through a long low budget. These separate real START and STOP conditions from data changes. SCL is also held high after a START, on an idle bus, and after a timeout. This checks the continuous-high rule, the firing cycle, and the idle state that follows a timeout.

// File: rtl/smbus_tmo_pkg.sv
`timescale 1ns/1ps
package smbus_tmo_pkg;

   // Converts a time in microseconds to whole clock cycles (rounded down).
   function automatic longint unsigned tmo_cycles(input longint unsigned clk_hz,
                                                  input longint unsigned usec);
      return (clk_hz * usec) / 64'd1_000_000;
   endfunction

   function automatic longint unsigned tmo_max(input longint unsigned a,
                                               input longint unsigned b);
      return (a > b) ? a : b;
   endfunction

   typedef enum logic [1:0] {
      BUS_IDLE_C  = 2'd0,
      BUS_START_C = 2'd1,
      BUS_STOP_C  = 2'd2
   } bus_cond_e;

endpackage

// File: rtl/smbus_tmo_sync.sv
`timescale 1ns/1ps
module smbus_tmo_sync #(
   parameter int                 WIDTH   = 2,
   parameter int                 STAGES  = 2,
   parameter logic [WIDTH-1:0]   RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [STAGES-1:0][WIDTH-1:0] chain;

   initial begin
      if (STAGES < 2) $error("smbus_tmo_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         chain <= {STAGES{RST_VAL}};
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) begin
            chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/smbus_tmo_cond.sv
`timescale 1ns/1ps
module smbus_tmo_cond
   import smbus_tmo_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      scl_s,
   input  logic      sda_s,
   output bus_cond_e cond_o
);

   logic scl_d;
   logic sda_d;

   always_ff @(posedge clk) begin
      if (rst) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   // SCL must be high both before and after the SDA edge.
   always_comb begin
      cond_o = BUS_IDLE_C;
      if (scl_s && scl_d) begin
         if (sda_d && !sda_s)      cond_o = BUS_START_C;
         else if (!sda_d && sda_s) cond_o = BUS_STOP_C;
      end
   end

endmodule

// File: rtl/smbus_tmo_acc.sv
`timescale 1ns/1ps
module smbus_tmo_acc #(
   parameter int W        = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         inc,
   input  logic [W-1:0] lim,
   output logic [W-1:0] cnt,
   output logic         hit
);

   generate
      if (SATURATE) begin : g_sat
         always_ff @(posedge clk) begin
            if (rst || clr)                cnt <= '0;
            else if (inc && (cnt != '1))   cnt <= cnt + 1'b1;
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (rst || clr)                cnt <= '0;
            else if (inc)                  cnt <= cnt + 1'b1;
         end
      end
   endgenerate

   assign hit = (cnt >= lim);

endmodule

// File: rtl/smbus_tmo_mon.sv
`timescale 1ns/1ps
module smbus_tmo_mon
   import smbus_tmo_pkg::*;
#(
   parameter longint unsigned CLK_HZ       = 100_000_000,
   parameter longint unsigned LOW_FAST_US  = 30_000,
   parameter longint unsigned LOW_SLOW_US  = 37_500,
   parameter longint unsigned HIGH_FAST_US = 60,
   parameter longint unsigned HIGH_SLOW_US = 75,
   parameter int              SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic scl_i,
   input  logic sda_i,
   input  logic grade_slow_i,
   output logic bus_rst_o
);

   localparam longint unsigned LOW_FAST_CYC  = tmo_cycles(CLK_HZ, LOW_FAST_US);
   localparam longint unsigned LOW_SLOW_CYC  = tmo_cycles(CLK_HZ, LOW_SLOW_US);
   localparam longint unsigned HIGH_FAST_CYC = tmo_cycles(CLK_HZ, HIGH_FAST_US);
   localparam longint unsigned HIGH_SLOW_CYC = tmo_cycles(CLK_HZ, HIGH_SLOW_US);
   localparam longint unsigned MAX_CYC       =
      tmo_max(tmo_max(LOW_FAST_CYC, LOW_SLOW_CYC), tmo_max(HIGH_FAST_CYC, HIGH_SLOW_CYC));
   localparam int              CNT_W         = $clog2(MAX_CYC + 1);

   localparam logic [CNT_W-1:0] LOW_FAST_L  = CNT_W'(LOW_FAST_CYC);
   localparam logic [CNT_W-1:0] LOW_SLOW_L  = CNT_W'(LOW_SLOW_CYC);
   localparam logic [CNT_W-1:0] HIGH_FAST_L = CNT_W'(HIGH_FAST_CYC);
   localparam logic [CNT_W-1:0] HIGH_SLOW_L = CNT_W'(HIGH_SLOW_CYC);

   initial begin
      if (LOW_FAST_CYC == 0 || LOW_SLOW_CYC == 0)
         $error("smbus_tmo_mon: low limit rounds to zero cycles");
      if (HIGH_FAST_CYC == 0 || HIGH_SLOW_CYC == 0)
         $error("smbus_tmo_mon: high limit rounds to zero cycles");
      if (SYNC_STAGES < 2)
         $error("smbus_tmo_mon: SYNC_STAGES must be at least 2");
   end

   // ---------------------------------------------------------------
   // Line synchronizer and condition detection
   // ---------------------------------------------------------------
   logic [1:0] line_s;
   logic       scl_s;
   logic       sda_s;
   bus_cond_e  cond;
   logic       start_w;
   logic       stop_w;

   smbus_tmo_sync #(
      .WIDTH   (2),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (2'b11)
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .d   ({scl_i, sda_i}),
      .q   (line_s)
   );

   assign scl_s = line_s[1];
   assign sda_s = line_s[0];

   smbus_tmo_cond u_cond (
      .clk    (clk),
      .rst    (rst),
      .scl_s  (scl_s),
      .sda_s  (sda_s),
      .cond_o (cond)
   );

   assign start_w = (cond == BUS_START_C);
   assign stop_w  = (cond == BUS_STOP_C);

   // ---------------------------------------------------------------
   // Limit selection
   // ---------------------------------------------------------------
   logic [CNT_W-1:0] low_lim;
   logic [CNT_W-1:0] high_lim;

   assign low_lim  = grade_slow_i ? LOW_SLOW_L  : LOW_FAST_L;
   assign high_lim = grade_slow_i ? HIGH_SLOW_L : HIGH_FAST_L;

   // ---------------------------------------------------------------
   // Transaction tracking and counters
   // ---------------------------------------------------------------
   logic             active_q;
   logic             fire_c;
   logic [CNT_W-1:0] low_cnt;
   logic [CNT_W-1:0] high_cnt;
   logic             low_hit;
   logic             high_hit;

   assign fire_c = active_q && (low_hit || high_hit);

   smbus_tmo_acc #(.W(CNT_W), .SATURATE(1'b1)) u_low (
      .clk (clk),
      .rst (rst),
      .clr (start_w || stop_w || fire_c),
      .inc (active_q && !scl_s),
      .lim (low_lim),
      .cnt (low_cnt),
      .hit (low_hit)
   );

   smbus_tmo_acc #(.W(CNT_W), .SATURATE(1'b1)) u_high (
      .clk (clk),
      .rst (rst),
      .clr (!scl_s || stop_w || fire_c),
      .inc (active_q && scl_s),
      .lim (high_lim),
      .cnt (high_cnt),
      .hit (high_hit)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         active_q  <= 1'b0;
         bus_rst_o <= 1'b0;
      end else begin
         bus_rst_o <= fire_c;
         if (start_w)                active_q <= 1'b1;
         else if (stop_w || fire_c)  active_q <= 1'b0;
      end
   end

endmodule

// File: rtl/smbus_tmo_chk.sv
`timescale 1ns/1ps
module smbus_tmo_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst,
   input logic         bus_rst_o,
   input logic         active_q,
   input logic         start_w,
   input logic         stop_w,
   input logic [W-1:0] low_cnt,
   input logic [W-1:0] high_cnt,
   input logic [W-1:0] low_lim,
   input logic [W-1:0] high_lim
);

   AST_START_OPENS: assert property (@(posedge clk) disable iff (rst)
      start_w |=> active_q); // R1

   AST_STOP_CLOSES: assert property (@(posedge clk) disable iff (rst)
      (stop_w && !start_w) |=> !active_q); // R1

   AST_LOW_FIRES: assert property (@(posedge clk) disable iff (rst)
      (active_q && low_cnt >= low_lim) |=> (bus_rst_o && low_cnt == '0)); // R2

   AST_HIGH_FIRES: assert property (@(posedge clk) disable iff (rst)
      (active_q && high_cnt >= high_lim) |=> (bus_rst_o && high_cnt == '0)); // R5

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
      !active_q |-> (low_cnt == '0 && high_cnt == '0)); // R4

   AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
      bus_rst_o |=> !bus_rst_o); // R6

   AST_PULSE_FROM_ACTIVE: assert property (@(posedge clk) disable iff (rst)
      bus_rst_o |-> $past(active_q)); // R6

endmodule

bind smbus_tmo_mon smbus_tmo_chk #(.W(CNT_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .bus_rst_o (bus_rst_o),
   .active_q  (active_q),
   .start_w   (start_w),
   .stop_w    (stop_w),
   .low_cnt   (low_cnt),
   .high_cnt  (high_cnt),
   .low_lim   (low_lim),
   .high_lim  (high_lim)
);

// File: tb/smbus_tmo_mon_tb.sv
`timescale 1ns/1ps
module smbus_tmo_mon_tb;

   localparam longint unsigned CLK_HZ = 200_000;
   localparam int LOW_F  = int'((64'd30000 * CLK_HZ) / 64'd1000000);
   localparam int LOW_S  = int'((64'd37500 * CLK_HZ) / 64'd1000000);
   localparam int HIGH_F = int'((64'd60    * CLK_HZ) / 64'd1000000);
   localparam int HIGH_S = int'((64'd75    * CLK_HZ) / 64'd1000000);

   typedef struct packed {
      logic        grade;
      int unsigned lo;
      int unsigned hi;
      int unsigned segs;
      logic        tgl;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 1000, 5, 5, 1'b0},   // below fast limit
      '{1'b0, 1000, 5, 6, 1'b1},   // exactly fast limit, SDA toggled in lows
      '{1'b1, 1000, 4, 7, 1'b0},   // over fast, below slow limit
      '{1'b1, 1500, 5, 5, 1'b0},   // exactly slow limit
      '{1'b0, 7000, 3, 1, 1'b0},   // one long low crosses fast limit
      '{1'b1, 2000, 5, 4, 1'b1}    // crosses slow limit mid-chunk
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic scl = 1'b1;
   logic sda = 1'b1;
   logic grade = 1'b0;
   logic bus_rst;

   int cyc = 0;
   int pulses = 0;
   int first_cyc = -1;
   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   smbus_tmo_mon #(.CLK_HZ(CLK_HZ)) u_dut (
      .clk          (clk),
      .rst          (rst),
      .scl_i        (scl),
      .sda_i        (sda),
      .grade_slow_i (grade),
      .bus_rst_o    (bus_rst)
   );

   always #5 clk = ~clk;

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (bus_rst === 1'b1) begin
         pulses = pulses + 1;
         if (pulses == 1) first_cyc = cyc;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      pulses = 0;
      first_cyc = -1;
   endtask

   initial begin
      #1800000;
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      int total;
      int exp_c;
      int lim;
      int k;

      // R7: reset state and idle behaviour during reset
      tick(5);
      chk(bus_rst === 1'b0, "R7 reset output", int'(bus_rst), 0);
      clear_mon();
      sda = 1'b0;
      tick(2);
      scl = 1'b0;
      tick(7000);
      chk(pulses == 0, "R7 no pulse while in reset", pulses, 0);
      rst = 1'b0;
      tick(7000);
      chk(pulses == 0, "R7 START seen in reset does not open", pulses, 0);
      scl = 1'b1;
      tick(3);
      sda = 1'b1;
      tick(20);

      // Table walk: cumulative low budget (R2, R3, R4, R1)
      for (int i = 0; i < NV; i++) begin
         grade = VEC[i].grade;
         tick(20);
         clear_mon();
         lim = VEC[i].grade ? LOW_S : LOW_F;
         total = 0;
         exp_c = -1;
         sda = 1'b0;                  // START
         tick(3);
         for (int s = 0; s < int'(VEC[i].segs); s++) begin
            scl = 1'b0;
            k = cyc;
            if (exp_c < 0 && total + int'(VEC[i].lo) >= lim)
               exp_c = k + (lim - total) + 3;
            total += int'(VEC[i].lo);
            if (VEC[i].tgl) begin
               tick(int'(VEC[i].lo) / 2);
               sda = 1'b1;
               tick(int'(VEC[i].lo) / 4);
               sda = 1'b0;
               tick(int'(VEC[i].lo) - int'(VEC[i].lo) / 2 - int'(VEC[i].lo) / 4);
            end else begin
               tick(int'(VEC[i].lo));
            end
            scl = 1'b1;
            tick(int'(VEC[i].hi));
         end
         sda = 1'b1;                  // STOP
         tick(20);
         chk(pulses == ((exp_c >= 0) ? 1 : 0), "R2 R3 pulse count", pulses,
             (exp_c >= 0) ? 1 : 0);
         if (exp_c >= 0)
            chk(first_cyc == exp_c, "R2 R3 R1 pulse cycle", first_cyc, exp_c);
         else
            chk(first_cyc == -1, "R4 R1 no early pulse", first_cyc, -1);
      end

      // R5: continuous high, fast grade
      grade = 1'b0;
      tick(20);
      clear_mon();
      sda = 1'b0;
      k = cyc;
      tick(100);
      chk(first_cyc == k + HIGH_F + 4, "R5 fast high timeout cycle", first_cyc, k + HIGH_F + 4);
      chk(pulses == 1, "R6 single pulse while high persists", pulses, 1);
      // R6: after timeout, long low without START is ignored
      scl = 1'b0;
      tick(7000);
      scl = 1'b1;
      tick(5);
      chk(pulses == 1, "R6 idle after timeout", pulses, 1);
      sda = 1'b1;
      tick(20);

      // R5: continuous high, slow grade
      grade = 1'b1;
      tick(20);
      clear_mon();
      sda = 1'b0;
      k = cyc;
      tick(100);
      chk(first_cyc == k + HIGH_S + 4, "R5 R3 slow high timeout cycle", first_cyc, k + HIGH_S + 4);
      sda = 1'b1;
      tick(20);

      // R5: SCL high on an idle bus has no effect
      clear_mon();
      tick(300);
      chk(pulses == 0, "R5 idle bus high ignored", pulses, 0);

      // R4: repeated START clears the low total
      grade = 1'b0;
      tick(20);
      clear_mon();
      sda = 1'b0;
      tick(3);
      scl = 1'b0;
      tick(4000);
      sda = 1'b1;
      tick(2);
      scl = 1'b1;
      tick(3);
      sda = 1'b0;                     // repeated START
      tick(3);
      scl = 1'b0;
      tick(4000);
      scl = 1'b1;
      tick(3);
      sda = 1'b1;
      tick(20);
      chk(pulses == 0, "R4 repeated START clears total", pulses, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule